// File: doc/BRIEF.md
# Bus-Sizing Endian Converter

This block sits between a queue that stores 36-bit long words and a narrow port whose transfer size is 36, 18 or 9 bits. On the read path it takes one long word from the queue side and hands it out as one, two or four narrow pieces. On the write path it collects narrow pieces and delivers one assembled long word back to the queue side. One piece counter and one slot mapping serve both paths, so the two directions always agree on piece order.

The transfer size and the piece order (most significant piece first, or least significant piece first) are captured while master reset is held. They stay fixed until the next master reset. A partial reset empties both paths, including any half-built long word, but keeps the captured settings. Every edge of the block uses a valid/ready handshake. A transfer takes place on a rising clock edge at which both valid and ready are high.

Top module: `bsz_width_adapter`

## Requirements
- R1: `cfg_width` is captured on every clock edge at which `rst_mr_n` is low, with the encoding 00 = 36-bit, 01 = 18-bit, 10 = 9-bit, 11 = 36-bit. Changes to `cfg_width` while `rst_mr_n` is high have no effect.
- R2: `cfg_little` is captured in the same way as `cfg_width`. A value of 0 sends the most significant piece first, and a value of 1 sends the least significant piece first. Changes while `rst_mr_n` is high have no effect.
- R3: In 36-bit mode, each long word passes through unchanged as a single transfer, in both directions.
- R4: In 18-bit mode, a long word becomes two transfers. On the read path the piece is on `nout_data[17:0]` and bits [35:18] are zero. On the write path the piece is taken from `nin_data[17:0]`. The piece order follows R2.
- R5: In 9-bit mode, a long word becomes four transfers. On the read path the piece is on `nout_data[8:0]` and the upper bits are zero. On the write path the piece is taken from `nin_data[8:0]`. The piece order follows R2.
- R6: On the write path, `pk_valid` stays low until the last piece of a long word has been accepted. It rises on the clock edge after that last piece, with the assembled word on `pk_data`.
- R7: A clock edge with `rst_pr_n` low does three things: it drops any pending or partly sent read-path word, it drops any partly assembled write-path word, and it clears both output valids. The captured width and order are kept.
- R8: While `nout_valid` or `pk_valid` is high and its ready input is low, that valid stays high and its data stays stable.
- R9: After master reset, `nout_valid` = 0, `pk_valid` = 0, `up_ready` = 1 and `nin_ready` = 1.
- R10: `nout_valid` rises on the edge after a long word is accepted. `up_ready` is high during the handshake of the last piece, so long words can stream with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_mr_n | input | 1 | Master reset, synchronous, active low; captures the configuration |
| rst_pr_n | input | 1 | Partial reset, synchronous, active low; keeps the configuration |
| cfg_width | input | 2 | Transfer size select, captured at master reset |
| cfg_little | input | 1 | Piece order select, captured at master reset |
| up_valid | input | 1 | Queue-side long word is valid (read path) |
| up_ready | output | 1 | Read path accepts a long word |
| up_data | input | 36 | Queue-side long word (read path) |
| nout_valid | output | 1 | Narrow piece is valid (read path) |
| nout_ready | input | 1 | Narrow consumer accepts the piece |
| nout_data | output | 36 | Narrow piece, zero-extended |
| nin_valid | input | 1 | Narrow piece is valid (write path) |
| nin_ready | output | 1 | Write path accepts a piece |
| nin_data | input | 36 | Narrow piece, low bits used per mode |
| pk_valid | output | 1 | Assembled long word is valid |
| pk_ready | input | 1 | Queue side accepts the long word |
| pk_data | output | 36 | Assembled long word |

## Verification
A long word accepted on the queue side appears as a piece on the edge after that handshake. An assembled word appears on `pk_data` on the edge after its last piece is accepted. Handshake readiness responds in the same cycle, because it is combinational. The bench therefore sets its inputs at the falling edge. It then waits a short delay and reads valid and ready, which tells it which handshakes the next rising edge will perform. It records those handshakes against its queues of expected pieces and words. Directed checks are made half a cycle after the edge that is expected to change an output: the edge after a reset, after a load, or after a last piece. The captured-settings checks disturb `cfg_width` and `cfg_little` after reset and then expect the piece order that was captured at reset.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

   typedef enum logic [1:0] {
      BSZ_W36  = 2'd0,
      BSZ_W18  = 2'd1,
      BSZ_W9   = 2'd2,
      BSZ_WRSV = 2'd3
   } bsz_width_e;

   // index of the final piece of a long word for a given transfer size
   function automatic logic [1:0] bsz_last_idx(input bsz_width_e m);
      case (m)
         BSZ_W18: return 2'd1;
         BSZ_W9:  return 2'd3;
         default: return 2'd0;
      endcase
   endfunction

   // slot of the long word that the k-th piece occupies
   function automatic logic [1:0] bsz_slot(input bsz_width_e m, input logic little,
                                           input logic [1:0] k);
      logic [1:0] last;
      last = bsz_last_idx(m);
      return little ? k : (last - k);
   endfunction

endpackage

// File: rtl/bsz_cfg_latch.sv
module bsz_cfg_latch
   import bsz_pkg::*;
(
   input  logic       clk,
   input  logic       rst_mr_n,
   input  logic [1:0] cfg_width,
   input  logic       cfg_little,
   output bsz_width_e mode_o,
   output logic       little_o
);

   bsz_width_e mode_q;
   logic       little_q;

   always_ff @(posedge clk) begin
      if (!rst_mr_n) begin
         mode_q   <= (cfg_width == 2'd3) ? BSZ_W36 : bsz_width_e'(cfg_width);
         little_q <= cfg_little;
      end
   end

   assign mode_o   = mode_q;
   assign little_o = little_q;

endmodule

// File: rtl/bsz_unpack.sv
module bsz_unpack
   import bsz_pkg::*;
#(
   parameter int WORD_W = 36
) (
   input  logic              clk,
   input  logic              clr,
   input  bsz_width_e        mode,
   input  logic              little,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic [WORD_W-1:0] up_data,
   output logic              nout_valid,
   input  logic              nout_ready,
   output logic [WORD_W-1:0] nout_data
);

   localparam int HALF_W = WORD_W / 2;
   localparam int QTR_W  = WORD_W / 4;

   logic [WORD_W-1:0] word_q;
   logic              hold_q;
   logic [1:0]        cnt_q;
   logic              last;
   logic [1:0]        slot;
   logic              load;
   logic              take;

   logic [HALF_W-1:0] half_sl [2];
   logic [QTR_W-1:0]  qtr_sl  [4];

   for (genvar h = 0; h < 2; h++) begin : g_half
      assign half_sl[h] = word_q[h*HALF_W +: HALF_W];
   end
   for (genvar q = 0; q < 4; q++) begin : g_qtr
      assign qtr_sl[q] = word_q[q*QTR_W +: QTR_W];
   end

   assign last     = (cnt_q == bsz_last_idx(mode));
   assign slot     = bsz_slot(mode, little, cnt_q);
   assign up_ready = !hold_q || (nout_ready && last);
   assign load     = up_valid && up_ready;
   assign take     = hold_q && nout_ready;

   always_ff @(posedge clk) begin
      if (clr) begin
         hold_q <= 1'b0;
         cnt_q  <= 2'd0;
         word_q <= '0;
      end else if (load) begin
         hold_q <= 1'b1;
         cnt_q  <= 2'd0;
         word_q <= up_data;
      end else if (take) begin
         if (last) begin
            hold_q <= 1'b0;
            cnt_q  <= 2'd0;
         end else begin
            cnt_q <= cnt_q + 2'd1;
         end
      end
   end

   always_comb begin
      case (mode)
         BSZ_W18: nout_data = {{(WORD_W-HALF_W){1'b0}}, half_sl[slot[0]]};
         BSZ_W9:  nout_data = {{(WORD_W-QTR_W){1'b0}}, qtr_sl[slot]};
         default: nout_data = word_q;
      endcase
   end

   assign nout_valid = hold_q;

endmodule

// File: rtl/bsz_pack.sv
module bsz_pack
   import bsz_pkg::*;
#(
   parameter int WORD_W = 36
) (
   input  logic              clk,
   input  logic              clr,
   input  bsz_width_e        mode,
   input  logic              little,
   input  logic              nin_valid,
   output logic              nin_ready,
   input  logic [WORD_W-1:0] nin_data,
   output logic              pk_valid,
   input  logic              pk_ready,
   output logic [WORD_W-1:0] pk_data
);

   localparam int HALF_W = WORD_W / 2;
   localparam int QTR_W  = WORD_W / 4;

   logic [WORD_W-1:0] acc_q;
   logic [WORD_W-1:0] out_q;
   logic              outv_q;
   logic [1:0]        cnt_q;
   logic              last;
   logic [1:0]        slot;
   logic              fire;
   logic [WORD_W-1:0] placed;
   logic [WORD_W-1:0] merged;

   assign last      = (cnt_q == bsz_last_idx(mode));
   assign slot      = bsz_slot(mode, little, cnt_q);
   assign nin_ready = !(last && outv_q && !pk_ready);
   assign fire      = nin_valid && nin_ready;

   always_comb begin
      case (mode)
         BSZ_W18: placed = WORD_W'(nin_data[HALF_W-1:0]) << (int'(slot[0]) * HALF_W);
         BSZ_W9:  placed = WORD_W'(nin_data[QTR_W-1:0]) << (int'(slot) * QTR_W);
         default: placed = nin_data;
      endcase
      merged = acc_q | placed;
   end

   always_ff @(posedge clk) begin
      if (clr) begin
         acc_q  <= '0;
         out_q  <= '0;
         outv_q <= 1'b0;
         cnt_q  <= 2'd0;
      end else begin
         if (outv_q && pk_ready) begin
            outv_q <= 1'b0;
         end
         if (fire) begin
            if (last) begin
               out_q  <= merged;
               outv_q <= 1'b1;
               acc_q  <= '0;
               cnt_q  <= 2'd0;
            end else begin
               acc_q <= merged;
               cnt_q <= cnt_q + 2'd1;
            end
         end
      end
   end

   assign pk_valid = outv_q;
   assign pk_data  = out_q;

endmodule

// File: rtl/bsz_width_adapter.sv
module bsz_width_adapter
   import bsz_pkg::*;
#(
   parameter int WORD_W = 36
) (
   input  logic              clk,
   input  logic              rst_mr_n,
   input  logic              rst_pr_n,
   input  logic [1:0]        cfg_width,
   input  logic              cfg_little,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic [WORD_W-1:0] up_data,
   output logic              nout_valid,
   input  logic              nout_ready,
   output logic [WORD_W-1:0] nout_data,
   input  logic              nin_valid,
   output logic              nin_ready,
   input  logic [WORD_W-1:0] nin_data,
   output logic              pk_valid,
   input  logic              pk_ready,
   output logic [WORD_W-1:0] pk_data
);

   if (WORD_W % 4 != 0) begin : g_bad_width
      $error("bsz_width_adapter: WORD_W must split into four equal pieces");
   end
   if (WORD_W < 4) begin : g_bad_small
      $error("bsz_width_adapter: WORD_W too small");
   end

   bsz_width_e mode_q;
   logic       little_q;
   logic       clr;

   assign clr = !rst_mr_n || !rst_pr_n;

   bsz_cfg_latch u_cfg (
      .clk        (clk),
      .rst_mr_n   (rst_mr_n),
      .cfg_width  (cfg_width),
      .cfg_little (cfg_little),
      .mode_o     (mode_q),
      .little_o   (little_q)
   );

   bsz_unpack #(.WORD_W(WORD_W)) u_unpack (
      .clk        (clk),
      .clr        (clr),
      .mode       (mode_q),
      .little     (little_q),
      .up_valid   (up_valid),
      .up_ready   (up_ready),
      .up_data    (up_data),
      .nout_valid (nout_valid),
      .nout_ready (nout_ready),
      .nout_data  (nout_data)
   );

   bsz_pack #(.WORD_W(WORD_W)) u_pack (
      .clk       (clk),
      .clr       (clr),
      .mode      (mode_q),
      .little    (little_q),
      .nin_valid (nin_valid),
      .nin_ready (nin_ready),
      .nin_data  (nin_data),
      .pk_valid  (pk_valid),
      .pk_ready  (pk_ready),
      .pk_data   (pk_data)
   );

endmodule

// File: rtl/bsz_checker.sv
module bsz_checker
   import bsz_pkg::*;
#(
   parameter int WORD_W = 36
) (
   input logic              clk,
   input logic              rst_mr_n,
   input logic              rst_pr_n,
   input logic [1:0]        mode,
   input logic              little,
   input logic              up_valid,
   input logic              up_ready,
   input logic              nout_valid,
   input logic              nout_ready,
   input logic [WORD_W-1:0] nout_data,
   input logic              pk_valid,
   input logic              pk_ready,
   input logic [WORD_W-1:0] pk_data
);

   localparam int HALF_W = WORD_W / 2;
   localparam int QTR_W  = WORD_W / 4;

   // R1 R2: captured settings never move outside master reset
   a_r1_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_mr_n)
      $past(rst_mr_n) |-> ($stable(mode) && $stable(little)));

   // R8: read-path piece held while stalled
   a_r8_nout_hold: assert property (@(posedge clk) disable iff (!rst_mr_n || !rst_pr_n)
      (nout_valid && !nout_ready) |=> (nout_valid && $stable(nout_data)));

   // R8: assembled word held while stalled
   a_r8_pk_hold: assert property (@(posedge clk) disable iff (!rst_mr_n || !rst_pr_n)
      (pk_valid && !pk_ready) |=> (pk_valid && $stable(pk_data)));

   // R10: accepted long word becomes visible on the next edge
   a_r10_load_visible: assert property (@(posedge clk) disable iff (!rst_mr_n || !rst_pr_n)
      (up_valid && up_ready) |=> nout_valid);

   // R7: partial reset empties both paths
   a_r7_flush: assert property (@(posedge clk) disable iff (!rst_mr_n)
      !rst_pr_n |=> (!nout_valid && !pk_valid));

   // R4: 18-bit pieces carry zeros above the piece
   a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_mr_n)
      (nout_valid && mode == BSZ_W18) |-> (nout_data[WORD_W-1:HALF_W] == '0));

   // R5: 9-bit pieces carry zeros above the piece
   a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_mr_n)
      (nout_valid && mode == BSZ_W9) |-> (nout_data[WORD_W-1:QTR_W] == '0));

endmodule

bind bsz_width_adapter bsz_checker #(.WORD_W(WORD_W)) u_bsz_chk (
   .clk        (clk),
   .rst_mr_n   (rst_mr_n),
   .rst_pr_n   (rst_pr_n),
   .mode       (mode_q),
   .little     (little_q),
   .up_valid   (up_valid),
   .up_ready   (up_ready),
   .nout_valid (nout_valid),
   .nout_ready (nout_ready),
   .nout_data  (nout_data),
   .pk_valid   (pk_valid),
   .pk_ready   (pk_ready),
   .pk_data    (pk_data)
);

// File: tb/tb_bsz_width_adapter.sv
`timescale 1ns/1ps
module tb_bsz_width_adapter;

   logic        clk = 1'b0;
   logic        rst_mr_n = 1'b0;
   logic        rst_pr_n = 1'b1;
   logic [1:0]  cfg_width = 2'd0;
   logic        cfg_little = 1'b0;
   logic        up_valid = 1'b0;
   logic        up_ready;
   logic [35:0] up_data = '0;
   logic        nout_valid;
   logic        nout_ready = 1'b0;
   logic [35:0] nout_data;
   logic        nin_valid = 1'b0;
   logic        nin_ready;
   logic [35:0] nin_data = '0;
   logic        pk_valid;
   logic        pk_ready = 1'b0;
   logic [35:0] pk_data;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   bsz_width_adapter dut (
      .clk(clk), .rst_mr_n(rst_mr_n), .rst_pr_n(rst_pr_n),
      .cfg_width(cfg_width), .cfg_little(cfg_little),
      .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
      .nout_valid(nout_valid), .nout_ready(nout_ready), .nout_data(nout_data),
      .nin_valid(nin_valid), .nin_ready(nin_ready), .nin_data(nin_data),
      .pk_valid(pk_valid), .pk_ready(pk_ready), .pk_data(pk_data)
   );

   function automatic int n_pieces(input logic [1:0] w);
      if (w == 2'd1) return 2;
      if (w == 2'd2) return 4;
      return 1;
   endfunction

   function automatic logic [35:0] exp_piece(input logic [35:0] word, input logic [1:0] w,
                                             input logic le, input int k);
      int n, pw, idx;
      logic [35:0] mask;
      n    = n_pieces(w);
      pw   = 36 / n;
      idx  = le ? k : (n - 1 - k);
      mask = (pw == 36) ? {36{1'b1}} : ((36'd1 << pw) - 36'd1);
      return (word >> (idx * pw)) & mask;
   endfunction

   function automatic string req_of(input logic [1:0] w);
      if (w == 2'd1) return "R4";
      if (w == 2'd2) return "R5";
      return "R3";
   endfunction

   function automatic logic [35:0] rnd36();
      return {$urandom(), $urandom()} & {36{1'b1}};
   endfunction

   task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic idle_inputs();
      up_valid = 1'b0; nout_ready = 1'b0; nin_valid = 1'b0; pk_ready = 1'b0;
   endtask

   task automatic do_mreset(input logic [1:0] w, input logic le);
      @(negedge clk);
      idle_inputs();
      rst_mr_n = 1'b0; rst_pr_n = 1'b1;
      cfg_width = w; cfg_little = le;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_mr_n = 1'b1;
      #1;
      chk("R9 nout_valid", {35'd0, nout_valid}, 36'd0);
      chk("R9 pk_valid",   {35'd0, pk_valid},   36'd0);
      chk("R9 up_ready",   {35'd0, up_ready},   36'd1);
      chk("R9 nin_ready",  {35'd0, nin_ready},  36'd1);
   endtask

   // random streaming on both paths; config inputs disturbed after reset (R1, R2)
   task automatic run_stream(input logic [1:0] w, input logic le, input int nwords);
      logic [35:0] up_q[$];
      logic [35:0] exp_n[$];
      logic [35:0] nin_q[$];
      logic [35:0] exp_pk[$];
      int n, pieces_in, words_out, guard;
      string rq;
      n = n_pieces(w);
      rq = {req_of(w), " R1 R2"};
      do_mreset(w, le);
      cfg_width  = (w == 2'd2) ? 2'd0 : 2'd2;
      cfg_little = ~le;
      for (int i = 0; i < nwords; i++) begin
         logic [35:0] a, b;
         a = rnd36(); b = rnd36();
         up_q.push_back(a);
         exp_pk.push_back(b);
         for (int k = 0; k < n; k++) begin
            exp_n.push_back(exp_piece(a, w, le, k));
            nin_q.push_back(exp_piece(b, w, le, k));
         end
      end
      pieces_in = 0; words_out = 0; guard = 0;
      while ((exp_n.size() > 0 || exp_pk.size() > 0) && guard < 20000) begin
         guard++;
         @(negedge clk);
         up_valid   = (up_q.size() > 0) && ($urandom() % 4 != 0);
         up_data    = (up_q.size() > 0) ? up_q[0] : rnd36();
         nout_ready = ($urandom() % 3 != 0);
         nin_valid  = (nin_q.size() > 0) && ($urandom() % 4 != 0);
         nin_data   = (nin_q.size() > 0) ? (nin_q[0] | (rnd36() & ~((36'd1 << (36 / n)) - 36'd1) & {36{n != 1}})) : rnd36();
         pk_ready   = ($urandom() % 3 != 0);
         #1;
         if (up_valid && up_ready) void'(up_q.pop_front());
         if (nout_valid && nout_ready) begin
            if (exp_n.size() == 0) chk({rq, " extra piece"}, nout_data, 36'hx);
            else chk({rq, " read piece"}, nout_data, exp_n.pop_front());
         end
         if (pk_valid && pk_ready) begin
            chk("R6 word only after last piece", {35'd0, pieces_in >= (words_out + 1) * n}, 36'd1);
            if (exp_pk.size() == 0) chk({rq, " extra word"}, pk_data, 36'hx);
            else chk({rq, " packed word"}, pk_data, exp_pk.pop_front());
            words_out++;
         end
         if (nin_valid && nin_ready) begin
            void'(nin_q.pop_front());
            pieces_in++;
         end
      end
      chk({rq, " stream drained"}, 36'(exp_n.size() + exp_pk.size()), 36'd0);
      @(negedge clk);
      idle_inputs();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin : main
      logic [35:0] wa, wb, wc, wd;
      void'($urandom(32'h5EED_0042));

      // random streams across every width encoding and both orders
      for (int w = 0; w < 4; w++) begin
         for (int le = 0; le < 2; le++) begin
            run_stream(2'(w), 1'(le), 40);
         end
      end

      // R6 + R7: write path, 9-bit big-endian, partial word discarded
      do_mreset(2'd2, 1'b0);
      wa = rnd36(); wb = rnd36();
      for (int k = 0; k < 2; k++) begin
         @(negedge clk); nin_valid = 1'b1; nin_data = exp_piece(wa, 2'd2, 1'b0, k);
      end
      @(negedge clk); nin_valid = 1'b0; rst_pr_n = 1'b0;
      @(negedge clk); rst_pr_n = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (k == 3) chk("R6 pk_valid low before last piece", {35'd0, pk_valid}, 36'd0);
         nin_valid = 1'b1; nin_data = exp_piece(wb, 2'd2, 1'b0, k);
      end
      @(negedge clk); nin_valid = 1'b0;
      chk("R6 pk_valid after last piece", {35'd0, pk_valid}, 36'd1);
      chk("R7 partial word dropped", pk_data, wb);
      pk_ready = 1'b1;
      @(negedge clk); pk_ready = 1'b0;

      // R7 + R10 + R8: read path
      wc = rnd36(); wd = rnd36();
      @(negedge clk); up_valid = 1'b1; up_data = wc;
      @(negedge clk); up_valid = 1'b0; nout_ready = 1'b1;
      @(negedge clk); nout_ready = 1'b0; rst_pr_n = 1'b0;
      @(negedge clk); rst_pr_n = 1'b1;
      #1 chk("R7 read path flushed", {35'd0, nout_valid}, 36'd0);
      @(negedge clk); up_valid = 1'b1; up_data = wd;
      @(negedge clk); up_valid = 1'b0;
      #1;
      chk("R10 nout_valid next edge", {35'd0, nout_valid}, 36'd1);
      chk("R7 width and order kept", nout_data, exp_piece(wd, 2'd2, 1'b0, 0));
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); #1;
         chk("R8 stalled piece stable", nout_data, exp_piece(wd, 2'd2, 1'b0, 0));
      end

      // R10: back-to-back long words in 36-bit mode, no idle cycle
      do_mreset(2'd0, 1'b1);
      @(negedge clk); up_valid = 1'b1; up_data = 36'h0_0000_0001; nout_ready = 1'b1;
      for (int i = 2; i <= 6; i++) begin
         @(negedge clk);
         #1;
         chk("R10 up_ready during last piece", {35'd0, up_ready}, 36'd1);
         chk("R3 pass-through word", nout_data, 36'(i - 1));
         up_data = 36'(i);
      end
      @(negedge clk); idle_inputs();

      summary();
      $finish;
   end

endmodule